// File: doc/BRIEF.md
# Signed Sequential Shift-Add Multiplier

This block multiplies two n-bit two's-complement numbers over several clocks, using a single adder/subtractor instead of a full array. A start request captures the multiplicand and the multiplier. On every clock after that, one partial product is added into a running accumulator, and the accumulator and the remaining multiplier bits then shift right together by one place. The multiplicand is added when the current multiplier bit is one, and nothing is added when it is zero.

The multiplier's top bit has negative weight. For that reason the partial product for the last bit is subtracted, and the accumulator shifts in copies of its own sign bit. Each sum is formed one bit wider than the operands, so the sign survives the shift.

The block accepts work only while it is idle. When the product is ready it raises a one-cycle completion pulse, and the registered 2n-bit result holds its value until the next operation finishes.

Top module: `smul_core`

## Requirements
- R1: After synchronous reset, `done` is 0 and `product` is 0.
- R2: A `start` sampled high while the block is idle captures `mcand` and `mplier` on that same edge and begins an operation.
- R3: `done` rises exactly N rising edges after the edge that accepted `start`, and never earlier.
- R4: `product` equals the signed product of `mcand` and `mplier`, written as a 2N-bit two's-complement value, for every pair of N-bit operands.
- R5: The most negative operand times itself gives the positive value 2^(2N-2), and the most negative operand times -1 gives +2^(N-1).
- R6: A `start` sampled while an operation is running has no effect. The operands applied with it are discarded, and neither the running result nor its completion time changes.
- R7: A `start` sampled in the cycle where `done` is high is accepted, so operations can run back to back with no idle cycle.
- R8: `product` keeps its last completed value on every cycle until the next `done`.
- R9: `done` is high for exactly one cycle per accepted operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a multiplication; used only when idle |
| mcand | input | N | Multiplicand, two's complement |
| mplier | input | N | Multiplier, two's complement |
| done | output | 1 | One-cycle pulse: the product is valid |
| product | output | 2N | Registered signed product |

## Verification
Two events can land on the same edge: the last add/shift step of one operation, which raises `done`, and the acceptance of a new `start`. The bench provokes this on every vector by driving the next operands and `start` in the very cycle where `done` is high. It then requires that the new operation completes in exactly N cycles with the correct signed product, while the previous result stays on `product` until then. A second `start` carrying scrambled operands is also injected in the middle of every operation. The result must still match the operands that were first accepted.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } smul_state_t;
endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic busy
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;

  smul_state_t     state_q;
  logic [CW-1:0]   cnt_q;

  assign busy = (state_q == ST_RUN);
  assign load = start && !busy;
  assign step = busy;
  assign last = busy && (cnt_q == CW'(N - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (start) state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (last) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smul_addsub.sv
module smul_addsub #(
  parameter int W = 9
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  output logic [W-1:0] sum
);
  logic [W-1:0] y_eff;

  assign y_eff = sub ? ~y : y;
  assign sum   = x + y_eff + {{(W-1){1'b0}}, sub};
endmodule

// File: rtl/smul_datapath.sv
module smul_datapath #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic           last,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic [N-1:0]   a_val,
  output logic [2*N-1:0] next_pb
);
  localparam int W = N + 1;

  logic [N-1:0] acc_q;
  logic [N-1:0] mul_q;
  logic [N-1:0] a_q;
  logic [W-1:0] acc_ext;
  logic [W-1:0] addend;
  logic [W-1:0] sum;
  logic [2*N:0] joined;

  assign acc_ext = {acc_q[N-1], acc_q};
  assign addend  = mul_q[0] ? {a_q[N-1], a_q} : '0;

  smul_addsub #(.W(W)) u_addsub (
    .x   (acc_ext),
    .y   (addend),
    .sub (last),
    .sum (sum)
  );

  assign joined  = {sum, mul_q};
  assign next_pb = joined[2*N:1];
  assign a_val   = a_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      mul_q <= '0;
      a_q   <= '0;
    end else if (load) begin
      acc_q <= '0;
      mul_q <= mplier;
      a_q   <= mcand;
    end else if (step) begin
      acc_q <= next_pb[2*N-1:N];
      mul_q <= next_pb[N-1:0];
    end
  end
endmodule

// File: rtl/smul_core.sv
module smul_core #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic           done,
  output logic [2*N-1:0] product
);
  logic           load;
  logic           step;
  logic           last;
  logic           busy;
  logic [N-1:0]   a_val;
  logic [2*N-1:0] next_pb;

  smul_ctrl #(.N(N)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .step  (step),
    .last  (last),
    .busy  (busy)
  );

  smul_datapath #(.N(N)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .step    (step),
    .last    (last),
    .mcand   (mcand),
    .mplier  (mplier),
    .a_val   (a_val),
    .next_pb (next_pb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      product <= '0;
    end else begin
      done <= last;
      if (last) product <= next_pb;
    end
  end
endmodule

// File: rtl/smul_core_chk.sv
module smul_core_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           done,
  input logic           busy,
  input logic [N-1:0]   a_val,
  input logic [2*N-1:0] product
);
  // R9: completion pulse lasts one cycle
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: completion only follows a running operation
  p_done_after_run_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  // R2: idle start begins an operation
  p_start_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R6: start while running leaves the captured multiplicand untouched
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> $stable(a_val));

  // R8: the result only moves on completion
  p_product_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(product) |-> done);
endmodule

bind smul_core smul_core_chk #(.N(N)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .done    (done),
  .busy    (busy),
  .a_val   (a_val),
  .product (product)
);

// File: tb/smul_core_bench.sv
`timescale 1ns/1ps
module smul_core_bench;
  localparam int N = 6;
  localparam int PW = 2 * N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [N-1:0]  mcand = '0;
  logic [N-1:0]  mplier = '0;
  logic          done;
  logic [PW-1:0] product;

  int n_checks = 0;
  int n_fail = 0;
  logic [PW-1:0] prev_exp = '0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  smul_core #(.N(N)) u_smul_core (
    .clk(clk), .rst(rst), .start(start), .mcand(mcand),
    .mplier(mplier), .done(done), .product(product)
  );

  task automatic check(input bit ok, input string req,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] sprod(input logic [N-1:0] a, input logic [N-1:0] b);
    longint sa, sb, pr;
    sa = a[N-1] ? longint'(a) - (longint'(1) <<< N) : longint'(a);
    sb = b[N-1] ? longint'(b) - (longint'(1) <<< N) : longint'(b);
    pr = sa * sb;
    return pr[PW-1:0];
  endfunction

  // called at a negedge; returns at the negedge where done is high
  task automatic run(input logic [N-1:0] a, input logic [N-1:0] b, input string req);
    int cyc;
    logic [PW-1:0] exp;
    exp = sprod(a, b);
    start = 1'b1; mcand = a; mplier = b;   // R7 when done is high here
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (done) break;
      // R6: mid-run start with scrambled operands
      start = (cyc == 1);
      mcand = ~a; mplier = b ^ {N{1'b1}};
      check(product == prev_exp, "R8 hold", product, prev_exp);
      if (cyc == 1) check(!done, "R9 pulse", {{(PW-1){1'b0}}, done}, '0);
      if (cyc > N + 4) begin
        check(1'b0, "R3 timeout", PW'(cyc), PW'(N));
        return;
      end
    end
    start = 1'b0;
    check(cyc == N, "R3 latency", PW'(cyc), PW'(N));
    check(product == exp, req, product, exp);
    prev_exp = exp;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(done == 1'b0, "R1 done", {{(PW-1){1'b0}}, done}, '0);
    check(product == '0, "R1 product", product, '0);
    run({1'b1, {(N-1){1'b0}}}, {1'b1, {(N-1){1'b0}}}, "R5 min*min");
    run({1'b1, {(N-1){1'b0}}}, {N{1'b1}}, "R5 min*-1");
    for (int i = 0; i < (1 << N); i++) begin
      for (int j = 0; j < (1 << N); j++) begin
        run(N'(i), N'(j), "R4 R2 R7 product");
      end
    end
    @(negedge clk);
    check(done == 1'b0, "R9 after", {{(PW-1){1'b0}}, done}, '0);
    check(product == prev_exp, "R8 final", product, prev_exp);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule